// File: doc/BRIEF.md
# Tiled View Address Generator

This block turns a pixel coordinate into an address inside a tiled address space. The caller supplies a pixel format (8, 16 or 32 bits per pixel), a 3-bit view orientation and an x/y coordinate. The block returns three things: a 32-bit address with the orientation and format tagged into its upper bits, the line stride that applies to the selected view, and a flag that marks the request as rejected.

Internally the block first checks the coordinate against the field widths of the chosen format. It then applies mirroring on either axis and an optional swap of the two axes. Finally it packs the result into the low address bits, shifted by an amount that depends on the format. Requests enter through a valid/ready handshake and results leave through a second one, one clock after acceptance. A stalled output holds its result and holds off new input.

Top module: `tiled_view_addr`

## Requirements
- R1: For a result that is not invalid, address bits [31:29] equal the orientation code and bits [28:27] equal the format code (0 = 8-bit, 1 = 16-bit, 2 = 32-bit).
- R2: Each format has an x shift and a y shift: 8-bit uses (0,0), 16-bit uses (0,1) and 32-bit uses (1,1). From these, x_bits = 14 − x shift and y_bits = 13 − y shift. If x > 2^x_bits − 1 or y > 2^y_bits − 1, the result is invalid, and an invalid result has address 0 and stride 0.
- R3: Format code 3 is reserved and always gives an invalid result.
- R4: Orientation bit 0 replaces x with (2^x_bits − 1) − x. Orientation bit 1 replaces y with (2^y_bits − 1) − y. Both are applied after the range check.
- R5: Orientation bit 2 selects axis swap. With swap the offset is (x << y_bits) + y; without it the offset is (y << x_bits) + x. The offset is shifted left by (x shift + y shift) and placed in address bits [26:0].
- R6: For a valid result the stride is 1 << (13 + x shift) when bit 2 is set, and 1 << (14 + y shift) otherwise.
- R7: A request accepted on a clock edge (in_valid_i and in_ready_o both high) appears on the outputs with out_valid_o high right after that edge.
- R8: While out_valid_o is high and out_ready_i is low, in_ready_o is low and the outputs hold their values.
- R9: After reset, out_valid_o is low and in_ready_o is high. With no request in flight and out_ready_i high, out_valid_o drops after one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request present |
| in_ready_o | output | 1 | Request can be taken |
| fmt_i | input | 2 | Pixel format code |
| orient_i | input | 3 | View orientation: bit0 x mirror, bit1 y mirror, bit2 axis swap |
| x_i | input | 14 | Pixel x coordinate |
| y_i | input | 13 | Pixel y coordinate |
| out_valid_o | output | 1 | Result present |
| out_ready_i | input | 1 | Result taken by consumer |
| addr_o | output | 32 | Tagged tiled address |
| stride_o | output | 32 | Line stride of the view |
| invalid_o | output | 1 | Coordinate out of range or format reserved |

## Verification
The properties check the handshake on every cycle: the one-cycle latency, holding during a stall, and the output draining when idle. They also check that the orientation and format tags track the accepted request, that a reserved format is always rejected, that a rejected result reads as zero, and that a valid stride is a single power of two. The actual offset arithmetic needs the bench's scenarios. Mirroring, axis swap, the format-dependent shift and the exact range boundaries (mask and mask + 1) can only be shown by comparing addresses against values computed independently across all formats and orientations, together with a stalled transfer.

// File: rtl/tva_pkg.sv
package tva_pkg;
  typedef enum logic [1:0] {
    FMT_B8   = 2'd0,
    FMT_B16  = 2'd1,
    FMT_B32  = 2'd2,
    FMT_RSVD = 2'd3
  } fmt_e;

  typedef struct packed {
    logic x_sh;
    logic y_sh;
    logic rsvd;
  } geom_t;

  function automatic geom_t geom_of(logic [1:0] f);
    geom_t g;
    unique case (fmt_e'(f))
      FMT_B8:  g = '{x_sh: 1'b0, y_sh: 1'b0, rsvd: 1'b0};
      FMT_B16: g = '{x_sh: 1'b0, y_sh: 1'b1, rsvd: 1'b0};
      FMT_B32: g = '{x_sh: 1'b1, y_sh: 1'b1, rsvd: 1'b0};
      default: g = '{x_sh: 1'b0, y_sh: 1'b0, rsvd: 1'b1};
    endcase
    return g;
  endfunction
endpackage

// File: rtl/tva_geom.sv
module tva_geom import tva_pkg::*; #(
  parameter int W_BITS = 14,
  parameter int H_BITS = 13
) (
  input  logic [1:0]        fmt_i,
  output logic [W_BITS-1:0] mask_x_o,
  output logic [H_BITS-1:0] mask_y_o,
  output logic              x_sh_o,
  output logic              y_sh_o,
  output logic              rsvd_o
);
  geom_t g;
  logic [W_BITS-1:0] ones_x;
  logic [H_BITS-1:0] ones_y;

  always_comb begin
    g        = geom_of(fmt_i);
    ones_x   = '1;
    ones_y   = '1;
    x_sh_o   = g.x_sh;
    y_sh_o   = g.y_sh;
    rsvd_o   = g.rsvd;
    mask_x_o = ones_x >> g.x_sh;
    mask_y_o = ones_y >> g.y_sh;
  end
endmodule

// File: rtl/tva_xform.sv
module tva_xform #(
  parameter int W_BITS = 14,
  parameter int H_BITS = 13,
  parameter int ADDR_W = 32,
  localparam int OFF_W = W_BITS + H_BITS,
  localparam int PK_W  = ADDR_W - 5
) (
  input  logic [1:0]        fmt_i,
  input  logic [2:0]        orient_i,
  input  logic [W_BITS-1:0] x_i,
  input  logic [H_BITS-1:0] y_i,
  input  logic [W_BITS-1:0] mask_x_i,
  input  logic [H_BITS-1:0] mask_y_i,
  input  logic              x_sh_i,
  input  logic              y_sh_i,
  input  logic              rsvd_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] stride_o,
  output logic              invalid_o
);
  logic              bad;
  logic [W_BITS-1:0] xm;
  logic [H_BITS-1:0] ym;
  logic [OFF_W-1:0]  x_ext, y_ext, off, packed_off;
  logic [1:0]        align;
  logic [ADDR_W-1:0] stride_raw;

  always_comb begin
    bad   = rsvd_i | (x_i > mask_x_i) | (y_i > mask_y_i);
    xm    = orient_i[0] ? (mask_x_i - x_i) : x_i;
    ym    = orient_i[1] ? (mask_y_i - y_i) : y_i;
    x_ext = OFF_W'(xm);
    y_ext = OFF_W'(ym);
    if (orient_i[2])
      off = (y_sh_i ? (x_ext << (H_BITS - 1)) : (x_ext << H_BITS)) + y_ext;
    else
      off = (x_sh_i ? (y_ext << (W_BITS - 1)) : (y_ext << W_BITS)) + x_ext;
    align      = {1'b0, x_sh_i} + {1'b0, y_sh_i};
    packed_off = off << align;
    stride_raw = orient_i[2] ? ((ADDR_W'(1) << H_BITS) << x_sh_i)
                             : ((ADDR_W'(1) << W_BITS) << y_sh_i);
    invalid_o  = bad;
    addr_o     = bad ? '0 : {orient_i, fmt_i, PK_W'(packed_off)};
    stride_o   = bad ? '0 : stride_raw;
  end
endmodule

// File: rtl/tva_stage.sv
module tva_stage #(
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [PW-1:0] data_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [PW-1:0] data_o
);
  logic          vld_q;
  logic [PW-1:0] data_q;

  assign in_ready_o  = ~vld_q | out_ready_i;
  assign out_valid_o = vld_q;
  assign data_o      = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else if (in_ready_o) begin
      vld_q <= in_valid_i;
      if (in_valid_i) data_q <= data_i;
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q && !out_ready_i |=> vld_q && $stable(data_q));
  // R9
  drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o && !in_valid_i |=> !vld_q);
endmodule

// File: rtl/tiled_view_addr.sv
module tiled_view_addr #(
  parameter int W_BITS = 14,
  parameter int H_BITS = 13,
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [1:0]        fmt_i,
  input  logic [2:0]        orient_i,
  input  logic [W_BITS-1:0] x_i,
  input  logic [H_BITS-1:0] y_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] stride_o,
  output logic              invalid_o
);
  localparam int PW = 2 * ADDR_W + 1;

  logic [W_BITS-1:0] mask_x;
  logic [H_BITS-1:0] mask_y;
  logic              x_sh, y_sh, rsvd;
  logic [ADDR_W-1:0] c_addr, c_stride;
  logic              c_inv;
  logic [PW-1:0]     res_d, res_q;

  tva_geom #(.W_BITS(W_BITS), .H_BITS(H_BITS)) u_geom (
    .fmt_i(fmt_i), .mask_x_o(mask_x), .mask_y_o(mask_y),
    .x_sh_o(x_sh), .y_sh_o(y_sh), .rsvd_o(rsvd)
  );

  tva_xform #(.W_BITS(W_BITS), .H_BITS(H_BITS), .ADDR_W(ADDR_W)) u_xform (
    .fmt_i(fmt_i), .orient_i(orient_i), .x_i(x_i), .y_i(y_i),
    .mask_x_i(mask_x), .mask_y_i(mask_y), .x_sh_i(x_sh), .y_sh_i(y_sh),
    .rsvd_i(rsvd), .addr_o(c_addr), .stride_o(c_stride), .invalid_o(c_inv)
  );

  assign res_d = {c_inv, c_stride, c_addr};

  tva_stage #(.PW(PW)) u_stage (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i),
    .in_ready_o(in_ready_o), .data_i(res_d), .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i), .data_o(res_q)
  );

  assign addr_o    = res_q[ADDR_W-1:0];
  assign stride_o  = res_q[2*ADDR_W-1:ADDR_W];
  assign invalid_o = res_q[PW-1];

  // R7
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o);
  // R1
  tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> invalid_o ||
      (addr_o[ADDR_W-1 -: 3] == $past(orient_i) && addr_o[ADDR_W-4 -: 2] == $past(fmt_i)));
  // R3
  rsvd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && fmt_i == 2'd3 |=> invalid_o);
  // R2
  zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && invalid_o |-> addr_o == '0 && stride_o == '0);
  // R6
  stride_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !invalid_o |-> $countones(stride_o) == 1);
  // R8
  stall_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(addr_o) && $stable(stride_o));
endmodule

// File: tb/sim_tiled_view_addr.sv
`timescale 1ns/1ps
module sim_tiled_view_addr;
  logic        clk = 0, rst_ni = 0;
  logic        in_valid = 0, out_ready = 1;
  logic [1:0]  fmt = 0;
  logic [2:0]  orient = 0;
  logic [13:0] x = 0;
  logic [12:0] y = 0;
  logic        in_ready, out_valid, invalid;
  logic [31:0] addr, stride;
  int total = 0, bad = 0;
  logic [31:0] lcg = 32'h1234_5678;

  always #2.5 clk = ~clk;

  tiled_view_addr u0 (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .fmt_i(fmt), .orient_i(orient), .x_i(x), .y_i(y), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .addr_o(addr), .stride_o(stride), .invalid_o(invalid)
  );

  task automatic check(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h (f=%0d o=%0d x=%0d y=%0d)", req, act, exp, fmt, orient, x, y);
    end
  endtask

  task automatic model(input int f, input int o, input longint xv, input longint yv,
                       output longint ea, output longint es, output int ei);
    int xs, ys, xb, yb;
    longint mx, my, xx, yy, off;
    xs = (f == 2) ? 1 : 0;
    ys = (f == 0) ? 0 : 1;
    xb = 14 - xs; yb = 13 - ys;
    mx = (64'd1 << xb) - 1; my = (64'd1 << yb) - 1;
    if (f == 3 || xv > mx || yv > my) begin
      ea = 0; es = 0; ei = 1;
    end else begin
      xx = o[0] ? mx - xv : xv;
      yy = o[1] ? my - yv : yv;
      off = o[2] ? (xx << yb) + yy : (yy << xb) + xx;
      ea = (longint'(o) << 29) | (longint'(f) << 27) | (off << (xs + ys));
      es = o[2] ? (64'd1 << (13 + xs)) : (64'd1 << (14 + ys));
      ei = 0;
    end
  endtask

  task automatic send_check(input int f, input int o, input logic [13:0] xv, input logic [12:0] yv);
    longint ea, es; int ei;
    @(negedge clk);
    fmt = f[1:0]; orient = o[2:0]; x = xv; y = yv; in_valid = 1;
    model(f, o, xv, yv, ea, es, ei);
    @(negedge clk);
    in_valid = 0;
    check("R7 valid", out_valid, 1);
    check(ei ? (f == 3 ? "R3 invalid" : "R2 invalid") : "R2 valid", invalid, ei);
    check(ei ? "R2 zero addr" : "R1 R4 R5 addr", addr, ea);
    check(ei ? "R2 zero stride" : "R6 stride", stride, es);
  endtask

  function automatic logic [13:0] pick_x(int k, int f);
    logic [13:0] m;
    m = (f == 2) ? 14'h1fff : 14'h3fff;
    case (k)
      0: return 0;
      1: return 1;
      2: return m;
      3: return m + 1;
      default: return 14'h2a5c & m;
    endcase
  endfunction

  function automatic logic [12:0] pick_y(int k, int f);
    logic [12:0] m;
    m = (f == 0) ? 13'h1fff : 13'h0fff;
    case (k)
      0: return 0;
      1: return 1;
      2: return m;
      3: return m + 1;
      default: return 13'h0b37 & m;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired (R7) act=hung exp=done");
    bad++; total++;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    longint ea1, es1, ea2, es2; int ei1, ei2;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R9 reset state
    check("R9 out_valid after reset", out_valid, 0);
    check("R9 in_ready after reset", in_ready, 1);

    for (int f = 0; f < 4; f++)
      for (int o = 0; o < 8; o++)
        for (int kx = 0; kx < 5; kx++)
          for (int ky = 0; ky < 5; ky++)
            send_check(f, o, pick_x(kx, f), pick_y(ky, f));

    for (int i = 0; i < 1500; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      send_check(int'(lcg[31:30]), int'(lcg[29:27]), lcg[13:0], lcg[26:14]);
    end

    // R9 drain when idle
    @(negedge clk);
    check("R9 drain", out_valid, 0);

    // R8 stall and hold
    @(negedge clk);
    out_ready = 0;
    fmt = 2'd1; orient = 3'd5; x = 14'd300; y = 13'd77; in_valid = 1;
    model(1, 5, 300, 77, ea1, es1, ei1);
    @(negedge clk);
    fmt = 2'd2; orient = 3'd2; x = 14'd4000; y = 13'd1000;
    model(2, 2, 4000, 1000, ea2, es2, ei2);
    for (int k = 0; k < 3; k++) begin
      check("R8 in_ready low", in_ready, 0);
      check("R8 hold valid", out_valid, 1);
      check("R8 hold addr", addr, ea1);
      check("R8 hold stride", stride, es1);
      @(negedge clk);
    end
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    check("R8 second addr", addr, ea2);
    check("R8 second stride", stride, es2);
    check("R8 second invalid", invalid, ei2);
    @(negedge clk);
    check("R9 final drain", out_valid, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule